// File: doc/BRIEF.md
# Programmable-Flag Offset Register Loader

This block keeps the two threshold offsets that a synchronous FIFO's programmable almost-empty and almost-full flags compare against. Each offset is split into two registers: a low byte and a high part. The high part's width follows the FIFO depth. Software or a host loads them through the FIFO's own data input. It holds a single load line low and pulses the write enable. Each accepted word lands in the next of the four registers, in a fixed cyclic order.

The registers can be read back over the same path. With the load line low and both read enables low, the next register in the same cyclic order appears on the data output. Writing and reading keep separate selection pointers. Both pointers survive across load sessions, so a host may load one or two registers, return to normal FIFO traffic and later resume with the register that follows. The assembled empty and full offsets are driven out continuously for the flag comparators.

Write and read share one clock here. A write and a read requested in the same cycle are refused: neither happens and a one-cycle error pulse is raised.

Top module: `flag_offset_loader`

## Requirements
- R1: On a clock edge with `rst` high, both offsets become 7, with the low byte 7 and the high part 0. `dout` becomes 0, `conflict` becomes 0, and both selection pointers return to the empty-offset low byte.
- R2: A write takes place on a rising `clk` when `load_n` and `wr_en_n` are both low and no read is requested. A low-byte register takes `din[7:0]`. A high-part register takes `din[HI_W-1:0]`, where HI_W = log2(DEPTH) - 8.
- R3: Successive writes target the registers in the order empty low (0), empty high (1), full low (2), full high (3). The fifth write returns to empty low.
- R4: The write pointer holds its position while no write takes place. A load session that resumes later continues with the register after the last one written.
- R5: With `load_n` high or `wr_en_n` high, no offset register changes.
- R6: A readback takes place on a rising `clk` when `load_n`, `rd_en_a_n` and `rd_en_b_n` are all low and no write is requested. From the next cycle `dout` shows the selected register, zero-extended to 9 bits. The read pointer then steps through the same cyclic order as the write pointer, independently of it.
- R7: With `load_n` high or either read enable high, `dout` and the read pointer hold their values.
- R8: When a write and a readback are both requested on the same edge, neither happens. Neither pointer moves, and `conflict` is high for exactly the following cycle.
- R9: `empty_ofs` and `full_ofs` equal {high part, low byte} of their registers. They are registered, so a write is visible from the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared write/read clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Offset register access select, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| din | input | 9 | FIFO data input used for loading |
| dout | output | 9 | Registered readback of the selected offset register |
| empty_ofs | output | log2(DEPTH) | Assembled almost-empty offset |
| full_ofs | output | log2(DEPTH) | Assembled almost-full offset |
| conflict | output | 1 | One-cycle pulse after a refused simultaneous write and read |

## Verification
The hardest states to reach are those where the two pointers sit at different positions and a refused conflicting request has gone by. In those states a pointer that slipped would only show several accesses later. The vector table builds that state deliberately. It writes past the wrap so the write pointer sits at the empty high register while reads start from the empty low one. It then inserts a conflicting request between two reads. Later reads and a final write expose any step that was lost or added. A reset issued in the middle of that state, followed by a read and a write, shows that both pointers return to the first register.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  localparam int BYTE_W = 8;
  localparam int RST_OFS = 7;

  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } ofs_sel_e;

  function automatic ofs_sel_e sel_next(input ofs_sel_e cur);
    return ofs_sel_e'(cur + 2'd1);
  endfunction

endpackage

// File: rtl/ofs_sel_ptr.sv
module ofs_sel_ptr
  import ofs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     adv,
  output ofs_sel_e sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= SEL_E_LO;
    end else if (adv) begin
      sel <= sel_next(sel);
    end
  end

  // R3: each advance moves exactly one position, wrapping modulo four
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
    adv |=> (2'(sel) - 2'($past(sel))) == 2'd1);

  // R4: without an advance the position is kept
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(sel));

  // R1: reset returns to the first register
  assert_ptr_reset_R1: assert property (@(posedge clk)
    rst |=> sel == SEL_E_LO);

endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
  import ofs_pkg::*;
#(
  parameter int HI_W  = 4,
  parameter int DIN_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_fire,
  input  ofs_sel_e                 wsel,
  input  logic [DIN_W-1:0]         din,
  input  ofs_sel_e                 rsel,
  output logic [DIN_W-1:0]         rd_data,
  output logic [BYTE_W+HI_W-1:0]   empty_ofs,
  output logic [BYTE_W+HI_W-1:0]   full_ofs
);

  localparam int OFS_W = BYTE_W + HI_W;

  logic [BYTE_W-1:0] e_lo, f_lo;
  logic [DIN_W-1:0]  e_hi_ext, f_hi_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_lo <= BYTE_W'(RST_OFS);
      f_lo <= BYTE_W'(RST_OFS);
    end else if (wr_fire) begin
      if (wsel == SEL_E_LO) e_lo <= din[BYTE_W-1:0];
      if (wsel == SEL_F_LO) f_lo <= din[BYTE_W-1:0];
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] e_hi, f_hi;
      always_ff @(posedge clk) begin
        if (rst) begin
          e_hi <= '0;
          f_hi <= '0;
        end else if (wr_fire) begin
          if (wsel == SEL_E_HI) e_hi <= din[HI_W-1:0];
          if (wsel == SEL_F_HI) f_hi <= din[HI_W-1:0];
        end
      end
      assign empty_ofs = {e_hi, e_lo};
      assign full_ofs  = {f_hi, f_lo};
      assign e_hi_ext  = DIN_W'(e_hi);
      assign f_hi_ext  = DIN_W'(f_hi);
    end else begin : g_no_hi
      assign empty_ofs = e_lo;
      assign full_ofs  = f_lo;
      assign e_hi_ext  = '0;
      assign f_hi_ext  = '0;
    end
  endgenerate

  always_comb begin
    unique case (rsel)
      SEL_E_LO: rd_data = DIN_W'(e_lo);
      SEL_E_HI: rd_data = e_hi_ext;
      SEL_F_LO: rd_data = DIN_W'(f_lo);
      default:  rd_data = f_hi_ext;
    endcase
  end

  // R5: offsets move only on an accepted write
  assert_ofs_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(empty_ofs) && $stable(full_ofs));

  // R2: a write to the empty low byte captures the data byte
  assert_elo_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && wsel == SEL_E_LO) |=> empty_ofs[BYTE_W-1:0] == $past(din[BYTE_W-1:0]));

  // R2: a write to the full low byte leaves the empty offset alone
  assert_flo_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && wsel == SEL_F_LO) |=> full_ofs[BYTE_W-1:0] == $past(din[BYTE_W-1:0])
                                      && $stable(empty_ofs));

  // R1: reset values
  assert_ofs_reset_R1: assert property (@(posedge clk)
    rst |=> empty_ofs == OFS_W'(RST_OFS) && full_ofs == OFS_W'(RST_OFS));

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback #(
  parameter int DIN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_fire,
  input  logic [DIN_W-1:0] rd_data,
  output logic [DIN_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (rd_fire) begin
      dout <= rd_data;
    end
  end

  // R7: output register holds when no readback is accepted
  assert_dout_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(dout));

  // R1: output cleared by reset
  assert_dout_reset_R1: assert property (@(posedge clk)
    rst |=> dout == '0);

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import ofs_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int DIN_W  = 9,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              wr_en_n,
  input  logic              rd_en_a_n,
  input  logic              rd_en_b_n,
  input  logic [DIN_W-1:0]  din,
  output logic [DIN_W-1:0]  dout,
  output logic [ADDR_W-1:0] empty_ofs,
  output logic [ADDR_W-1:0] full_ofs,
  output logic              conflict
);

  localparam int HI_W = ADDR_W - BYTE_W;

  logic     wr_req, rd_req, wr_fire, rd_fire;
  ofs_sel_e wsel, rsel;
  logic [DIN_W-1:0] rd_data;

  assign wr_req  = !load_n && !wr_en_n;
  assign rd_req  = !load_n && !rd_en_a_n && !rd_en_b_n;
  assign wr_fire = wr_req && !rd_req;
  assign rd_fire = rd_req && !wr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      conflict <= 1'b0;
    end else begin
      conflict <= wr_req && rd_req;
    end
  end

  ofs_sel_ptr u_wr_ptr (
    .clk (clk),
    .rst (rst),
    .adv (wr_fire),
    .sel (wsel)
  );

  ofs_sel_ptr u_rd_ptr (
    .clk (clk),
    .rst (rst),
    .adv (rd_fire),
    .sel (rsel)
  );

  ofs_reg_bank #(
    .HI_W  (HI_W),
    .DIN_W (DIN_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (wr_fire),
    .wsel      (wsel),
    .din       (din),
    .rsel      (rsel),
    .rd_data   (rd_data),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
  );

  ofs_readback #(
    .DIN_W (DIN_W)
  ) u_rb (
    .clk     (clk),
    .rst     (rst),
    .rd_fire (rd_fire),
    .rd_data (rd_data),
    .dout    (dout)
  );

  // R8: a simultaneous request changes nothing and raises the pulse
  assert_conflict_refused_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && rd_req) |=> conflict && $stable(wsel) && $stable(rsel)
                           && $stable(empty_ofs) && $stable(full_ofs) && $stable(dout));

  // R8: the pulse lasts only one cycle when the requests separate
  assert_conflict_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && rd_req) |=> !conflict);

  // R4: the write pointer is kept while the load line is high
  assert_wptr_session_R4: assert property (@(posedge clk) disable iff (rst)
    load_n |=> $stable(wsel) && $stable(rsel));

endmodule

// File: tb/tb_flag_offset_loader.sv
module tb_flag_offset_loader;

  localparam int DEPTH = 4096;
  localparam int AW    = 12;
  localparam int NV    = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_n, wr_en_n, rd_en_a_n, rd_en_b_n;
  logic [8:0]    din;
  logic [8:0]    dout;
  logic [AW-1:0] empty_ofs, full_ofs;
  logic          conflict;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  flag_offset_loader #(.DEPTH(DEPTH)) dut (
    .clk       (clk),
    .rst       (rst),
    .load_n    (load_n),
    .wr_en_n   (wr_en_n),
    .rd_en_a_n (rd_en_a_n),
    .rd_en_b_n (rd_en_b_n),
    .din       (din),
    .dout      (dout),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .conflict  (conflict)
  );

  // {load_n, wr_en_n, rd_en_a_n, rd_en_b_n} | din | exp dout | exp empty | exp full | exp conflict
  localparam logic [46:0] VEC [NV] = '{
    {4'b0011, 9'h0A5, 9'h000, 12'h0A5, 12'h007, 1'b0},
    {4'b0011, 9'h1F3, 9'h000, 12'h3A5, 12'h007, 1'b0},
    {4'b1011, 9'h055, 9'h000, 12'h3A5, 12'h007, 1'b0},
    {4'b0011, 9'h012, 9'h000, 12'h3A5, 12'h012, 1'b0},
    {4'b0011, 9'h0C9, 9'h000, 12'h3A5, 12'h912, 1'b0},
    {4'b0011, 9'h03C, 9'h000, 12'h33C, 12'h912, 1'b0},
    {4'b0111, 9'h1FF, 9'h000, 12'h33C, 12'h912, 1'b0},
    {4'b0100, 9'h000, 9'h03C, 12'h33C, 12'h912, 1'b0},
    {4'b0110, 9'h000, 9'h03C, 12'h33C, 12'h912, 1'b0},
    {4'b0100, 9'h000, 9'h003, 12'h33C, 12'h912, 1'b0},
    {4'b0000, 9'h077, 9'h003, 12'h33C, 12'h912, 1'b1},
    {4'b0100, 9'h000, 9'h012, 12'h33C, 12'h912, 1'b0},
    {4'b1100, 9'h000, 9'h012, 12'h33C, 12'h912, 1'b0},
    {4'b0100, 9'h000, 9'h009, 12'h33C, 12'h912, 1'b0},
    {4'b0100, 9'h000, 9'h03C, 12'h33C, 12'h912, 1'b0},
    {4'b0011, 9'h1E7, 9'h03C, 12'h73C, 12'h912, 1'b0}
  };

  localparam string TAG [NV] = '{
    "R2 write empty low", "R2 write empty high", "R5 load high ignored",
    "R4 resume at full low", "R9 full assembled", "R3 wrap to empty low",
    "R5 write enable high ignored", "R6 read empty low", "R7 one read enable high",
    "R6 read empty high", "R8 conflict refused", "R8 read pointer kept",
    "R7 load high no read", "R6 read full high", "R3 read wraps",
    "R4 write after conflict"
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ctl, input logic [8:0] d);
    {load_n, wr_en_n, rd_en_a_n, rd_en_b_n} = ctl;
    din = d;
  endtask

  task automatic check_all(input string tag, input logic [8:0] e_dout,
                           input logic [AW-1:0] e_emp, input logic [AW-1:0] e_full,
                           input logic e_conf);
    check(tag, "dout", 32'(dout), 32'(e_dout));
    check(tag, "empty_ofs", 32'(empty_ofs), 32'(e_emp));
    check(tag, "full_ofs", 32'(full_ofs), 32'(e_full));
    check(tag, "conflict", 32'(conflict), 32'(e_conf));
  endtask

  initial begin
    rst = 1'b1;
    drive(4'b1111, 9'h000);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_all("R1 reset", 9'h000, 12'h007, 12'h007, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][46:43], VEC[i][42:34]);
      @(negedge clk);
      check_all(TAG[i], VEC[i][33:25], VEC[i][24:13], VEC[i][12:1], VEC[i][0]);
    end

    // R1: reset from a loaded state with both pointers away from the start
    drive(4'b1111, 9'h000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 mid reset", 9'h000, 12'h007, 12'h007, 1'b0);

    // R1: read pointer back at empty low, which holds 7
    drive(4'b0100, 9'h000);
    @(negedge clk);
    check("R1 rptr reset", "dout", 32'(dout), 32'h007);
    // R6: high part default reads back as zero
    @(negedge clk);
    check("R6 empty high default", "dout", 32'(dout), 32'h000);

    // R1: write pointer back at empty low
    drive(4'b0011, 9'h101);
    @(negedge clk);
    check("R1 wptr reset", "empty_ofs", 32'(empty_ofs), 32'h001);
    check("R1 wptr reset", "full_ofs", 32'(full_ofs), 32'h007);

    drive(4'b1111, 9'h000);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule